// File: doc/BRIEF.md
# Control-Register Access Checker

This block executes the three read-modify-write instructions that touch a core's control and status registers: swap (write the source, return the old value), set bits and clear bits. One operation is presented per cycle together with a 12-bit register address, the source operand, a flag that tells whether the source register index (or immediate) is zero, and the hart's current privilege level. The block decides from the address bits, the privilege, the counter-enable masks and the floating-point status field whether the access is allowed. Exactly one cycle later it reports the outcome, the old value for the destination register, and any store write.

The register contents live outside the block. A combinational read port returns the stored value for a physical address that the block selects. A registered write port carries the updated value back. Both floating-point sub-fields share one stored word, so partial writes are merged here. The user-visible counters are aliases of the machine counter locations.

Top module: `csr_access_unit`

## Requirements
- R1: An access is illegal when the privilege input (0 user, 1 supervisor, 3 machine) is numerically lower than address bits [9:8].
- R2: An address with bits [11:10] equal to 2'b11 is read-only. Any write attempt to it is illegal, while a read of it is legal.
- R3: Op code 0 (swap) always writes the source operand and returns the value read before the write. The response and the store write appear on the first clock edge after the operation is presented.
- R4: Op code 1 stores old OR source and op code 2 stores old AND NOT source. When the source-zero flag is set, these two ops do not write and do not count as a write for any legality rule.
- R5: The user cycle (0xC00) and instret (0xC02) counters read the stored machine counters at 0xB00 and 0xB02. The read is legal only when bit addr[4:0] of the enable mask is set. Machine mode uses an all-ones mask. Supervisor mode uses the supervisor mask. Any other privilege uses the user mask.
- R6: Any access to 0x001, 0x002 or 0x003 is illegal while the 2-bit FP status input is 0.
- R7: The FP control word is stored at 0x003 with the rounding mode in bits [7:5] and the flags in bits [4:0]. Address 0x001 reads and writes only the flags, 0x002 only the rounding mode, and 0x003 both fields. Every write stores the merged 8-bit word.
- R8: Writes to 0xB00, 0xB02 and 0x301 are illegal, while reads of them return the stored value.
- R9: Reads of 0xF11, 0xF12 and 0xF13 return zero.
- R10: An address outside the decoded set, or op code 3, is illegal. The decoded set is 0x001–0x003, 0x140, 0x141, 0x300, 0x301, 0x340, 0x341, 0xB00, 0xB02, 0xC00, 0xC02 and 0xF11–0xF14.
- R11: An illegal access asserts the illegal flag and performs no store write. It leaves the destination write enable low and returns zero data.
- R12: After reset, no response is valid and no store write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | An operation is presented this cycle |
| op_i | input | 2 | 0 swap, 1 set bits, 2 clear bits, 3 reserved |
| csr_addr_i | input | 12 | Register address |
| src_i | input | XLEN | Source operand |
| src_zero_i | input | 1 | Source register index or immediate is zero |
| priv_i | input | 2 | Current privilege level |
| fs_i | input | 2 | Floating-point status field |
| ucnt_en_i | input | CNT_W | User counter-enable mask |
| scnt_en_i | input | CNT_W | Supervisor counter-enable mask |
| st_raddr_o | output | 12 | Storage read address |
| st_rdata_i | input | XLEN | Storage read data, combinational |
| st_we_o | output | 1 | Storage write enable |
| st_waddr_o | output | 12 | Storage write address |
| st_wdata_o | output | XLEN | Storage write data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_illegal_o | output | 1 | Access raised illegal instruction |
| rsp_rd_we_o | output | 1 | Destination register write enable |
| rsp_rd_data_o | output | XLEN | Old register value for the destination |

## Verification
The hardest case to reach is an access that is legal by every other rule but still changes only part of a shared word. Examples are a flag set or a rounding-mode swap that must keep the other field of the FP word intact. The stimulus first enables the FP status and swaps the rounding mode. It then sets flag bits, so that each merge reads back a word the previous write left behind. A second hard case is a counter read whose legality flips only with one mask bit. The bench toggles the single enable bit at addr[4:0] between otherwise identical reads in user and supervisor mode.

// File: rtl/csr_chk_pkg.sv
package csr_chk_pkg;

  typedef enum logic [1:0] {
    OP_SWAP = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_RSVD = 2'd3
  } csr_op_e;

  typedef enum logic [3:0] {
    K_NONE,
    K_PLAIN,
    K_FLAGS,
    K_RMODE,
    K_FPWORD,
    K_UCNT,
    K_MCNT,
    K_ISA,
    K_ZERO
  } csr_kind_e;

  localparam logic [1:0]  PRIV_S    = 2'd1;
  localparam logic [1:0]  PRIV_M    = 2'd3;
  localparam int          FLAGS_W   = 5;
  localparam int          RMODE_W   = 3;
  localparam int          FPWORD_W  = FLAGS_W + RMODE_W;
  localparam logic [11:0] FPWORD_AD = 12'h003;

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
  import csr_chk_pkg::*;
(
  input  logic [11:0] addr_i,
  output csr_kind_e   kind_o,
  output logic [11:0] phys_o
);

  always_comb begin
    kind_o = K_NONE;
    phys_o = addr_i;
    case (addr_i)
      12'h001: begin kind_o = K_FLAGS;  phys_o = FPWORD_AD; end
      12'h002: begin kind_o = K_RMODE;  phys_o = FPWORD_AD; end
      12'h003: begin kind_o = K_FPWORD; phys_o = FPWORD_AD; end
      12'hC00,
      12'hC02: begin kind_o = K_UCNT;   phys_o = {4'hB, addr_i[7:0]}; end
      12'hB00,
      12'hB02: kind_o = K_MCNT;
      12'h301: kind_o = K_ISA;
      12'hF11,
      12'hF12,
      12'hF13: kind_o = K_ZERO;
      12'hF14,
      12'h300,
      12'h340,
      12'h341,
      12'h140,
      12'h141: kind_o = K_PLAIN;
      default: kind_o = K_NONE;
    endcase
  end

endmodule

// File: rtl/csr_access_gate.sv
module csr_access_gate
  import csr_chk_pkg::*;
#(
  parameter int CNT_W     = 32,
  localparam int CNT_IDX_W = $clog2(CNT_W)
) (
  input  csr_kind_e            kind_i,
  input  csr_op_e              op_i,
  input  logic [1:0]           min_priv_i,
  input  logic                 ro_i,
  input  logic [CNT_IDX_W-1:0] cnt_idx_i,
  input  logic                 src_zero_i,
  input  logic [1:0]           priv_i,
  input  logic [1:0]           fs_i,
  input  logic [CNT_W-1:0]     ucnt_en_i,
  input  logic [CNT_W-1:0]     scnt_en_i,
  output logic                 illegal_o,
  output logic                 do_write_o
);

  logic             wr_attempt;
  logic             priv_low;
  logic             fp_off;
  logic [CNT_W-1:0] cnt_mask;
  logic             cnt_bad;
  logic             wr_forbid;

  always_comb begin
    wr_attempt = (op_i == OP_SWAP) || !src_zero_i;
    priv_low   = priv_i < min_priv_i;
    fp_off     = (kind_i inside {K_FLAGS, K_RMODE, K_FPWORD}) && (fs_i == 2'b00);
    if (priv_i == PRIV_M)      cnt_mask = '1;
    else if (priv_i == PRIV_S) cnt_mask = scnt_en_i;
    else                       cnt_mask = ucnt_en_i;
    cnt_bad    = (kind_i == K_UCNT) && !cnt_mask[cnt_idx_i];
    wr_forbid  = wr_attempt && (kind_i inside {K_MCNT, K_ISA});
    illegal_o  = (op_i == OP_RSVD) || (kind_i == K_NONE) || priv_low ||
                 (wr_attempt && ro_i) || fp_off || cnt_bad || wr_forbid;
    do_write_o = !illegal_o && wr_attempt;
  end

endmodule

// File: rtl/csr_wdata_merge.sv
module csr_wdata_merge
  import csr_chk_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  csr_kind_e       kind_i,
  input  csr_op_e         op_i,
  input  logic [XLEN-1:0] raw_i,
  input  logic [XLEN-1:0] src_i,
  output logic [XLEN-1:0] old_o,
  output logic [XLEN-1:0] store_o
);

  localparam int PAD_FL = XLEN - FLAGS_W;
  localparam int PAD_RM = XLEN - RMODE_W;
  localparam int PAD_FW = XLEN - FPWORD_W;

  logic [XLEN-1:0] arch_new;

  always_comb begin
    case (kind_i)
      K_FLAGS:  old_o = {{PAD_FL{1'b0}}, raw_i[FLAGS_W-1:0]};
      K_RMODE:  old_o = {{PAD_RM{1'b0}}, raw_i[FPWORD_W-1:FLAGS_W]};
      K_FPWORD: old_o = {{PAD_FW{1'b0}}, raw_i[FPWORD_W-1:0]};
      K_ZERO:   old_o = '0;
      default:  old_o = raw_i;
    endcase

    case (op_i)
      OP_SET:  arch_new = old_o | src_i;
      OP_CLR:  arch_new = old_o & ~src_i;
      default: arch_new = src_i;
    endcase

    case (kind_i)
      K_FLAGS:  store_o = {{PAD_FW{1'b0}}, raw_i[FPWORD_W-1:FLAGS_W],
                           arch_new[FLAGS_W-1:0]};
      K_RMODE:  store_o = {{PAD_FW{1'b0}}, arch_new[RMODE_W-1:0],
                           raw_i[FLAGS_W-1:0]};
      K_FPWORD: store_o = {{PAD_FW{1'b0}}, arch_new[FPWORD_W-1:0]};
      default:  store_o = arch_new;
    endcase
  end

endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
  import csr_chk_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid_i,
  input  logic [1:0]       op_i,
  input  logic [11:0]      csr_addr_i,
  input  logic [XLEN-1:0]  src_i,
  input  logic             src_zero_i,
  input  logic [1:0]       priv_i,
  input  logic [1:0]       fs_i,
  input  logic [CNT_W-1:0] ucnt_en_i,
  input  logic [CNT_W-1:0] scnt_en_i,
  output logic [11:0]      st_raddr_o,
  input  logic [XLEN-1:0]  st_rdata_i,
  output logic             st_we_o,
  output logic [11:0]      st_waddr_o,
  output logic [XLEN-1:0]  st_wdata_o,
  output logic             rsp_valid_o,
  output logic             rsp_illegal_o,
  output logic             rsp_rd_we_o,
  output logic [XLEN-1:0]  rsp_rd_data_o
);

  localparam int CNT_IDX_W = $clog2(CNT_W);

  csr_op_e         op;
  csr_kind_e       kind;
  logic [11:0]     phys;
  logic            illegal;
  logic            do_write;
  logic [XLEN-1:0] old_val;
  logic [XLEN-1:0] store_val;

  assign op = csr_op_e'(op_i);

  csr_addr_decode u_decode (
    .addr_i (csr_addr_i),
    .kind_o (kind),
    .phys_o (phys)
  );

  csr_access_gate #(.CNT_W(CNT_W)) u_gate (
    .kind_i     (kind),
    .op_i       (op),
    .min_priv_i (csr_addr_i[9:8]),
    .ro_i       (csr_addr_i[11:10] == 2'b11),
    .cnt_idx_i  (csr_addr_i[CNT_IDX_W-1:0]),
    .src_zero_i (src_zero_i),
    .priv_i     (priv_i),
    .fs_i       (fs_i),
    .ucnt_en_i  (ucnt_en_i),
    .scnt_en_i  (scnt_en_i),
    .illegal_o  (illegal),
    .do_write_o (do_write)
  );

  csr_wdata_merge #(.XLEN(XLEN)) u_merge (
    .kind_i  (kind),
    .op_i    (op),
    .raw_i   (st_rdata_i),
    .src_i   (src_i),
    .old_o   (old_val),
    .store_o (store_val)
  );

  assign st_raddr_o = phys;

  // next-state
  logic            rsp_valid_d, rsp_illegal_d, rsp_rd_we_d, st_we_d;
  logic [XLEN-1:0] rd_data_d;

  always_comb begin
    rsp_valid_d   = op_valid_i;
    rsp_illegal_d = op_valid_i && illegal;
    rsp_rd_we_d   = op_valid_i && !illegal;
    st_we_d       = op_valid_i && do_write;
    rd_data_d     = illegal ? '0 : old_val;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o   <= 1'b0;
      rsp_illegal_o <= 1'b0;
      rsp_rd_we_o   <= 1'b0;
      st_we_o       <= 1'b0;
    end else begin
      rsp_valid_o   <= rsp_valid_d;
      rsp_illegal_o <= rsp_illegal_d;
      rsp_rd_we_o   <= rsp_rd_we_d;
      st_we_o       <= st_we_d;
    end
  end

  // data registers, loaded only when an op is presented
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rd_data_o <= '0;
      st_waddr_o    <= '0;
      st_wdata_o    <= '0;
    end else if (op_valid_i) begin
      rsp_rd_data_o <= rd_data_d;
      st_waddr_o    <= phys;
      st_wdata_o    <= store_val;
    end
  end

  AST_PRIV_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_i && (priv_i < csr_addr_i[9:8]) |=> rsp_illegal_o); // R1

  AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_i && (csr_addr_i[11:10] == 2'b11) && ((op_i == 2'd0) || !src_zero_i)
    |=> rsp_illegal_o && !st_we_o); // R2

  AST_SWAP_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && !rsp_illegal_o && $past(op_valid_i && op_i == 2'd0) |-> st_we_o); // R3

  AST_ZERO_SRC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_i && (op_i != 2'd0) && src_zero_i |=> !st_we_o); // R4

  AST_FP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_i && (fs_i == 2'b00) && (csr_addr_i inside {12'h001, 12'h002, 12'h003})
    |=> rsp_illegal_o); // R6

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal_o |-> !st_we_o && !rsp_rd_we_o && (rsp_rd_data_o == '0)); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid_i |=> !rsp_valid_o && !st_we_o); // R12

endmodule

// File: tb/test_csr_access_unit.sv
`timescale 1ns/1ps
module test_csr_access_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [1:0]  op;
  logic [11:0] addr;
  logic [31:0] src;
  logic        src_zero;
  logic [1:0]  priv;
  logic [1:0]  fs;
  logic [31:0] ucnt, scnt;
  logic [11:0] st_raddr, st_waddr;
  logic [31:0] st_rdata, st_wdata;
  logic        st_we;
  logic        rsp_valid, rsp_illegal, rsp_rd_we;
  logic [31:0] rsp_rd_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  csr_access_unit i_csr_access_unit (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .op_i(op),
    .csr_addr_i(addr), .src_i(src), .src_zero_i(src_zero), .priv_i(priv),
    .fs_i(fs), .ucnt_en_i(ucnt), .scnt_en_i(scnt), .st_raddr_o(st_raddr),
    .st_rdata_i(st_rdata), .st_we_o(st_we), .st_waddr_o(st_waddr),
    .st_wdata_o(st_wdata), .rsp_valid_o(rsp_valid), .rsp_illegal_o(rsp_illegal),
    .rsp_rd_we_o(rsp_rd_we), .rsp_rd_data_o(rsp_rd_data)
  );

  // register storage model
  logic [31:0] mem [0:15];

  function automatic int slot(input logic [11:0] a);
    case (a)
      12'h003: return 1;
      12'hB00: return 2;
      12'hB02: return 3;
      12'h301: return 4;
      12'hF14: return 5;
      12'h300: return 6;
      12'h340: return 7;
      12'h341: return 8;
      12'h140: return 9;
      12'h141: return 10;
      default: return 0;
    endcase
  endfunction

  assign st_rdata = mem[slot(st_raddr)];
  always @(posedge clk) if (st_we) mem[slot(st_waddr)] <= st_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic [11:0] a,
                        input logic [31:0] s, input logic z, input logic [1:0] p);
    @(negedge clk);
    op_valid = 1'b1; op = o; addr = a; src = s; src_zero = z; priv = p;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic expect_legal(input string req, input logic [31:0] rd,
                              input logic we, input logic [31:0] wd);
    chk({req, " valid"}, {31'd0, rsp_valid}, 32'd1);
    chk({req, " illegal"}, {31'd0, rsp_illegal}, 32'd0);
    chk({req, " rd_we"}, {31'd0, rsp_rd_we}, 32'd1);
    chk({req, " rd_data"}, rsp_rd_data, rd);
    chk({req, " st_we"}, {31'd0, st_we}, {31'd0, we});
    if (we) chk({req, " st_wdata"}, st_wdata, wd);
  endtask

  task automatic expect_illegal(input string req);
    chk({req, " valid"}, {31'd0, rsp_valid}, 32'd1);
    chk({req, " illegal"}, {31'd0, rsp_illegal}, 32'd1);
    chk({req, " R11 rd_we"}, {31'd0, rsp_rd_we}, 32'd0);
    chk({req, " R11 st_we"}, {31'd0, st_we}, 32'd0);
    chk({req, " R11 rd_data"}, rsp_rd_data, 32'd0);
  endtask

  task automatic t_reset;
    chk("R12 valid after reset", {31'd0, rsp_valid}, 32'd0);
    chk("R12 st_we after reset", {31'd0, st_we}, 32'd0);
  endtask

  task automatic t_swap;
    run_op(2'd0, 12'h340, 32'h0000_1234, 1'b0, 2'd3);
    expect_legal("R3 swap", 32'hAAAA_5555, 1'b1, 32'h0000_1234);
    chk("R3 waddr", {20'd0, st_waddr}, 32'h340);
  endtask

  task automatic t_set_clear;
    run_op(2'd1, 12'h340, 32'h0000_00F0, 1'b0, 2'd3);
    expect_legal("R4 set", 32'h0000_1234, 1'b1, 32'h0000_12F4);
    run_op(2'd2, 12'h340, 32'h0000_0204, 1'b0, 2'd3);
    expect_legal("R4 clear", 32'h0000_12F4, 1'b1, 32'h0000_10F0);
    run_op(2'd1, 12'h340, 32'h0000_FFFF, 1'b1, 2'd3);
    expect_legal("R4 set zero-src", 32'h0000_10F0, 1'b0, 32'h0);
    run_op(2'd2, 12'h340, 32'h0000_FFFF, 1'b1, 2'd3);
    expect_legal("R4 clear zero-src unchanged", 32'h0000_10F0, 1'b0, 32'h0);
  endtask

  task automatic t_readonly;
    run_op(2'd1, 12'hF14, 32'hFFFF_FFFF, 1'b1, 2'd3);
    expect_legal("R2 read-only read", 32'h0000_0007, 1'b0, 32'h0);
    run_op(2'd0, 12'hF14, 32'h0, 1'b0, 2'd3);
    expect_illegal("R2 read-only swap");
    run_op(2'd2, 12'hF14, 32'h1, 1'b0, 2'd3);
    expect_illegal("R2 read-only clear");
  endtask

  task automatic t_priv;
    run_op(2'd1, 12'h340, 32'h0, 1'b1, 2'd1);
    expect_illegal("R1 super on machine reg");
    run_op(2'd0, 12'h140, 32'h0000_0011, 1'b0, 2'd1);
    expect_legal("R1 super on super reg", 32'h5A5A_0000, 1'b1, 32'h0000_0011);
    run_op(2'd1, 12'h140, 32'h0, 1'b1, 2'd0);
    expect_illegal("R1 user on super reg");
  endtask

  task automatic t_counters;
    ucnt = 32'h0; scnt = 32'h0;
    run_op(2'd1, 12'hC00, 32'h0, 1'b1, 2'd0);
    expect_illegal("R5 user cycle masked");
    ucnt = 32'h1;
    run_op(2'd1, 12'hC00, 32'h0, 1'b1, 2'd0);
    expect_legal("R5 user cycle enabled", 32'h0000_1000, 1'b0, 32'h0);
    run_op(2'd1, 12'hC02, 32'h0, 1'b1, 2'd1);
    expect_illegal("R5 super instret masked");
    scnt = 32'h4;
    run_op(2'd1, 12'hC02, 32'h0, 1'b1, 2'd1);
    expect_legal("R5 super instret enabled", 32'h0000_2000, 1'b0, 32'h0);
    ucnt = 32'h0; scnt = 32'h0;
    run_op(2'd1, 12'hC02, 32'h0, 1'b1, 2'd3);
    expect_legal("R5 machine ignores masks", 32'h0000_2000, 1'b0, 32'h0);
  endtask

  task automatic t_fp;
    fs = 2'b00;
    run_op(2'd1, 12'h001, 32'h0, 1'b1, 2'd0);
    expect_illegal("R6 flags read fp off");
    run_op(2'd0, 12'h002, 32'h2, 1'b0, 2'd0);
    expect_illegal("R6 rmode write fp off");
    fs = 2'b01;
    run_op(2'd1, 12'h001, 32'h0, 1'b1, 2'd0);
    expect_legal("R7 flags read", 32'h0000_0013, 1'b0, 32'h0);
    run_op(2'd1, 12'h002, 32'h0, 1'b1, 2'd0);
    expect_legal("R7 rmode read", 32'h0000_0005, 1'b0, 32'h0);
    run_op(2'd0, 12'h002, 32'h2, 1'b0, 2'd0);
    expect_legal("R7 rmode swap merge", 32'h0000_0005, 1'b1, 32'h0000_0053);
    run_op(2'd1, 12'h003, 32'h0, 1'b1, 2'd0);
    expect_legal("R7 word readback", 32'h0000_0053, 1'b0, 32'h0);
    run_op(2'd1, 12'h001, 32'h8, 1'b0, 2'd0);
    expect_legal("R7 flags set merge", 32'h0000_0013, 1'b1, 32'h0000_005B);
    run_op(2'd0, 12'h003, 32'hFFFF_FFFF, 1'b0, 2'd0);
    expect_legal("R7 word swap truncates", 32'h0000_005B, 1'b1, 32'h0000_00FF);
  endtask

  task automatic t_forbidden;
    run_op(2'd1, 12'hB00, 32'h0, 1'b1, 2'd3);
    expect_legal("R8 mcycle read", 32'h0000_1000, 1'b0, 32'h0);
    run_op(2'd0, 12'hB00, 32'h5, 1'b0, 2'd3);
    expect_illegal("R8 mcycle write");
    run_op(2'd1, 12'h301, 32'h4, 1'b0, 2'd3);
    expect_illegal("R8 isa set");
    run_op(2'd1, 12'h301, 32'h0, 1'b1, 2'd3);
    expect_legal("R8 isa read", 32'h4000_1104, 1'b0, 32'h0);
    run_op(2'd1, 12'hF12, 32'h0, 1'b1, 2'd3);
    expect_legal("R9 id read zero", 32'h0, 1'b0, 32'h0);
    run_op(2'd2, 12'hF11, 32'h0, 1'b1, 2'd3);
    expect_legal("R9 id read zero 2", 32'h0, 1'b0, 32'h0);
  endtask

  task automatic t_undecoded;
    run_op(2'd1, 12'h7C0, 32'h0, 1'b1, 2'd3);
    expect_illegal("R10 undecoded");
    run_op(2'd3, 12'h340, 32'h1, 1'b0, 2'd3);
    expect_illegal("R10 reserved op");
    run_op(2'd1, 12'h340, 32'h0, 1'b1, 2'd3);
    expect_legal("R11 state kept", 32'h0000_10F0, 1'b0, 32'h0);
  endtask

  initial begin
    mem[0]  <= 32'h0;         mem[1]  <= 32'h0000_00B3;
    mem[2]  <= 32'h0000_1000; mem[3]  <= 32'h0000_2000;
    mem[4]  <= 32'h4000_1104; mem[5]  <= 32'h0000_0007;
    mem[6]  <= 32'h0;         mem[7]  <= 32'hAAAA_5555;
    mem[8]  <= 32'h0;         mem[9]  <= 32'h5A5A_0000;
    mem[10] <= 32'h0;         mem[11] <= 32'h0;
    mem[12] <= 32'h0;         mem[13] <= 32'h0;
    mem[14] <= 32'h0;         mem[15] <= 32'h0;
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op = 2'd0; addr = 12'h0; src = 32'h0;
    src_zero = 1'b0; priv = 2'd3; fs = 2'b01; ucnt = 32'h0; scnt = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_swap();
    t_set_clear();
    t_readonly();
    t_priv();
    t_counters();
    t_fp();
    t_forbidden();
    t_undecoded();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule